// File: doc/BRIEF.md
# Rotate, Shift and Digit Unit

This unit performs single-bit rotates and shifts on an 8-bit or 16-bit operand. It also performs the two nibble rotations that move a 12-bit digit group spread over the low nibble of an accumulator byte and a memory byte. The surrounding datapath drives one request per cycle with `valid_i`. One clock later the unit returns the registered result, the updated accumulator and memory bytes, and a six-flag word. Fetching and writing back the memory byte is left to the caller.

The operand, memory byte, accumulator and carry all arrive as inputs. The carry result is registered along with the other outputs, so the caller can feed `flag_c_o` back as the next `carry_i`. While no legal request is issued, every output holds its last value.

Top module: `rsd_unit`

## Requirements
- R1: After reset `valid_o` is 0 and `result_o`, `acc_o`, `mem_o` and all six flags are 0.
- R2: Code 0 (rotate left through carry): the result is the operand shifted left one place with `carry_i` in bit 0, and the carry takes the old top bit.
- R3: Code 1 (rotate right through carry): the result is the operand shifted right one place with `carry_i` in the top bit, and the carry takes the old bit 0.
- R4: Code 2 (circular left) copies the old top bit into bit 0 and into the carry. Code 3 (circular right) copies the old bit 0 into the top bit and into the carry.
- R5: Code 4 (arithmetic shift left): the result is the operand shifted left one place with 0 in bit 0, and the carry takes the old top bit.
- R6: `wide_i`=1 works on bits 15:0 with bit 15 as the top bit. `wide_i`=0 works on bits 7:0 with bit 7 as the top bit, ignores `operand_i[15:8]`, and returns 0 in `result_o[15:8]`.
- R7: For codes 0 to 4 the flags are set as follows. S is the result top bit. Z is 1 when the result within the width is zero. P/V is 1 when that result has an even number of ones. H and N are 0. `acc_o` and `mem_o` echo `acc_i` and `mem_i`.
- R8: Code 5 (digit left) has three effects. The new memory byte is {mem[3:0], acc[3:0]}. The new accumulator is {acc[7:4], mem[7:4]}. `result_o` is {8'h00, new memory byte}.
- R9: Code 6 (digit right) has three effects. The new memory byte is {acc[3:0], mem[7:4]}. The new accumulator is {acc[7:4], mem[3:0]}. `result_o` is {8'h00, new memory byte}.
- R10: For codes 5 and 6 the carry flag equals `carry_i`. S, Z and P/V are taken from the new accumulator. H and N are 0.
- R11: Code 7 is ignored. `valid_o` is 0 on the next cycle and every other output keeps its value.
- R12: A legal request with `valid_i`=1 at a rising edge appears on the outputs with `valid_o`=1 right after that edge. With no request, `valid_o` falls to 0 and the data outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0..7) |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| operand_i | input | 16 | Rotate/shift operand |
| mem_i | input | 8 | Memory byte for digit operations |
| acc_i | input | 8 | Accumulator byte |
| carry_i | input | 1 | Carry in |
| valid_o | output | 1 | Result strobe |
| result_o | output | 16 | Rotate/shift result or new memory byte |
| acc_o | output | 8 | Updated accumulator |
| mem_o | output | 8 | Updated memory byte |
| flag_s_o | output | 1 | Sign |
| flag_z_o | output | 1 | Zero |
| flag_h_o | output | 1 | Half carry (always 0) |
| flag_pv_o | output | 1 | Even parity |
| flag_n_o | output | 1 | Subtract (always 0) |
| flag_c_o | output | 1 | Carry |

## Verification
The outputs are registered one stage after the request, so any fault in the datapath shows at the ports on the very next cycle.
- A wrong width select would leave nonzero upper result bits in byte mode.
- A mis-wired carry path would show in `flag_c_o`, or in the bit that rotates in at either end.
- A swapped nibble path in the digit operations would put an accumulator or memory nibble in the wrong field.
- A broken hold path would let a code-7 request, or an idle cycle, change the outputs or raise `valid_o`.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RLT  = 3'd0,
    OP_RRT  = 3'd1,
    OP_RLC  = 3'd2,
    OP_RRC  = 3'd3,
    OP_SLA  = 3'd4,
    OP_DGL  = 3'd5,
    OP_DGR  = 3'd6,
    OP_NONE = 3'd7
  } rsd_op_e;
endpackage

// File: rtl/rsd_shift_core.sv
module rsd_shift_core
  import rsd_pkg::*;
#(
  parameter int W = 8
) (
  input  rsd_op_e        op_i,
  input  logic [W-1:0]   val_i,
  input  logic           cin_i,
  output logic [W-1:0]   res_o,
  output logic           cout_o
);
  always_comb begin
    res_o  = val_i;
    cout_o = cin_i;
    case (op_i)
      OP_RLT: begin res_o = {val_i[W-2:0], cin_i};      cout_o = val_i[W-1]; end
      OP_RRT: begin res_o = {cin_i, val_i[W-1:1]};      cout_o = val_i[0];   end
      OP_RLC: begin res_o = {val_i[W-2:0], val_i[W-1]}; cout_o = val_i[W-1]; end
      OP_RRC: begin res_o = {val_i[0], val_i[W-1:1]};   cout_o = val_i[0];   end
      OP_SLA: begin res_o = {val_i[W-2:0], 1'b0};       cout_o = val_i[W-1]; end
      default: ;
    endcase
  end

  // circular rotates keep the population count
  always_comb begin
    if (op_i == OP_RLC || op_i == OP_RRC)
      AST_CIRC_ONES: assert ($countones(res_o) == $countones(val_i)) else $error("circular ones"); // R4
  end
endmodule

// File: rtl/rsd_digit_core.sv
module rsd_digit_core
  import rsd_pkg::*;
(
  input  logic              left_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] mem_i,
  output logic [BYTE_W-1:0] acc_o,
  output logic [BYTE_W-1:0] mem_o
);
  logic [NIB_W-1:0] a_lo, m_lo, m_hi;
  assign a_lo = acc_i[NIB_W-1:0];
  assign m_lo = mem_i[NIB_W-1:0];
  assign m_hi = mem_i[BYTE_W-1:NIB_W];

  always_comb begin
    if (left_i) begin
      mem_o = {m_lo, a_lo};
      acc_o = {acc_i[BYTE_W-1:NIB_W], m_hi};
    end else begin
      mem_o = {a_lo, m_hi};
      acc_o = {acc_i[BYTE_W-1:NIB_W], m_lo};
    end
  end

  always_comb begin
    AST_DIGIT_ONES: assert ($countones({acc_o[NIB_W-1:0], mem_o}) ==
                            $countones({a_lo, mem_i})) else $error("digit ones"); // R8
  end
endmodule

// File: rtl/rsd_flag_gen.sv
module rsd_flag_gen
  import rsd_pkg::*;
(
  input  logic [WORD_W-1:0] val_i,
  input  logic              wide_i,
  output logic              s_o,
  output logic              z_o,
  output logic              pv_o
);
  localparam logic [WORD_W-1:0] BYTE_MASK = WORD_W'({BYTE_W{1'b1}});
  logic [WORD_W-1:0] masked;

  assign masked = wide_i ? val_i : (val_i & BYTE_MASK);
  assign s_o    = wide_i ? val_i[WORD_W-1] : val_i[BYTE_W-1];
  assign z_o    = (masked == '0);
  assign pv_o   = ~^masked;
endmodule

// File: rtl/rsd_unit.sv
module rsd_unit
  import rsd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic [BYTE_W-1:0] mem_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic [BYTE_W-1:0] acc_o,
  output logic [BYTE_W-1:0] mem_o,
  output logic              flag_s_o,
  output logic              flag_z_o,
  output logic              flag_h_o,
  output logic              flag_pv_o,
  output logic              flag_n_o,
  output logic              flag_c_o
);
  localparam int N_WIDTHS = 2;

  rsd_op_e op;
  logic    is_digit, fire;
  assign op       = rsd_op_e'(op_i);
  assign is_digit = (op == OP_DGL) || (op == OP_DGR);
  assign fire     = valid_i && (op != OP_NONE);

  logic [WORD_W-1:0] sh_res [N_WIDTHS];
  logic              sh_c   [N_WIDTHS];

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    localparam int GW = (g == 0) ? BYTE_W : WORD_W;
    logic [GW-1:0] r;
    logic          c;
    rsd_shift_core #(.W(GW)) u_core (
      .op_i   (op),
      .val_i  (operand_i[GW-1:0]),
      .cin_i  (carry_i),
      .res_o  (r),
      .cout_o (c)
    );
    assign sh_res[g] = WORD_W'(r);
    assign sh_c[g]   = c;
  end

  logic [BYTE_W-1:0] dg_acc, dg_mem;
  rsd_digit_core u_digit (
    .left_i (op == OP_DGL),
    .acc_i  (acc_i),
    .mem_i  (mem_i),
    .acc_o  (dg_acc),
    .mem_o  (dg_mem)
  );

  logic [WORD_W-1:0] res_sel, flag_src;
  logic              c_sel, f_s, f_z, f_pv;
  assign res_sel  = is_digit ? WORD_W'(dg_mem) : (wide_i ? sh_res[1] : sh_res[0]);
  assign c_sel    = is_digit ? carry_i : (wide_i ? sh_c[1] : sh_c[0]);
  assign flag_src = is_digit ? WORD_W'(dg_acc) : res_sel;

  rsd_flag_gen u_flags (
    .val_i  (flag_src),
    .wide_i (wide_i && !is_digit),
    .s_o    (f_s),
    .z_o    (f_z),
    .pv_o   (f_pv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      acc_o     <= '0;
      mem_o     <= '0;
      flag_s_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_h_o  <= 1'b0;
      flag_pv_o <= 1'b0;
      flag_n_o  <= 1'b0;
      flag_c_o  <= 1'b0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        result_o  <= res_sel;
        acc_o     <= is_digit ? dg_acc : acc_i;
        mem_o     <= is_digit ? dg_mem : mem_i;
        flag_s_o  <= f_s;
        flag_z_o  <= f_z;
        flag_h_o  <= 1'b0;
        flag_pv_o <= f_pv;
        flag_n_o  <= 1'b0;
        flag_c_o  <= c_sel;
      end
    end
  end

  AST_FIRE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> valid_o) else $error("no valid"); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> (!valid_o && $stable(result_o) && $stable(acc_o) && $stable(mem_o) && $stable(flag_c_o)))
    else $error("outputs moved"); // R11
  AST_BYTE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !wide_i) |=> (result_o[WORD_W-1:BYTE_W] == '0)) else $error("upper byte"); // R6
  AST_DIGIT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && is_digit) |=> (flag_c_o == $past(carry_i))) else $error("digit carry"); // R10
  AST_DIGIT_ACC_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && is_digit) |=> (acc_o[BYTE_W-1:NIB_W] == $past(acc_i[BYTE_W-1:NIB_W])))
    else $error("acc high nibble"); // R10
  AST_HN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!flag_h_o && !flag_n_o)) else $error("h/n set"); // R7
  AST_ZERO_NOT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_z_o) |-> !flag_s_o) else $error("zero and sign"); // R7
endmodule

// File: tb/rsd_unit_tb.sv
`timescale 1ns/1ps
module rsd_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        valid_i = 1'b0, wide_i = 1'b0, carry_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] operand_i = '0;
  logic [7:0]  mem_i = '0, acc_i = '0;
  logic        valid_o, fs, fz, fh, fpv, fn, fc;
  logic [15:0] result_o;
  logic [7:0]  acc_o, mem_o;

  rsd_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .wide_i(wide_i),
    .operand_i(operand_i), .mem_i(mem_i), .acc_i(acc_i), .carry_i(carry_i),
    .valid_o(valid_o), .result_o(result_o), .acc_o(acc_o), .mem_o(mem_o),
    .flag_s_o(fs), .flag_z_o(fz), .flag_h_o(fh), .flag_pv_o(fpv), .flag_n_o(fn), .flag_c_o(fc)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [37:0] q_exp[$];
  string       q_tag[$];

  function automatic logic [37:0] gold(logic [2:0] op, logic wide, logic [15:0] x,
                                       logic [7:0] m, logic [7:0] a, logic cin);
    logic [15:0] mask, v, r;
    logic [7:0]  na, nm;
    logic        top, c;
    int          w;
    w    = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    v    = x & mask;
    top  = v[w-1];
    r = v; c = cin; na = a; nm = m;
    case (op)
      3'd0: begin r = (v << 1) | {15'b0, cin}; c = top; end
      3'd1: begin r = (v >> 1) | ({15'b0, cin} << (w-1)); c = v[0]; end
      3'd2: begin r = (v << 1) | {15'b0, top}; c = top; end
      3'd3: begin r = (v >> 1) | ({15'b0, v[0]} << (w-1)); c = v[0]; end
      3'd4: begin r = v << 1; c = top; end
      3'd5: begin nm = {m[3:0], a[3:0]}; na = {a[7:4], m[7:4]}; end
      default: begin nm = {a[3:0], m[7:4]}; na = {a[7:4], m[3:0]}; end
    endcase
    if (op >= 3'd5)
      return {8'h00, nm, na, nm, na[7], na == 8'h00, 1'b0, ~^na, 1'b0, cin};
    r = r & mask;
    return {r, a, m, r[w-1], r == 16'h0, 1'b0, ~^r, 1'b0, c};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic send(logic [2:0] op, logic wide, logic [15:0] x, logic [7:0] m,
                      logic [7:0] a, logic cin, string tag);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; wide_i = wide; operand_i = x; mem_i = m; acc_i = a; carry_i = cin;
    q_exp.push_back(gold(op, wide, x, m, a, cin));
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o && !done) begin
      if (q_exp.size() == 0) check("R12 unexpected valid", 64'(valid_o), 64'(0));
      else begin
        logic [37:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, 64'({result_o, acc_o, mem_o, fs, fz, fh, fpv, fn, fc}), 64'(e));
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [37:0] snap;
    lfsr = 32'h1234_5678;
    repeat (2) @(negedge clk);
    check("R1 reset state", 64'({valid_o, result_o, acc_o, mem_o, fs, fz, fh, fpv, fn, fc}), 64'(0));
    rst_n = 1'b1;

    send(3'd0, 1'b0, 16'h0081, 8'h11, 8'h22, 1'b0, "R2 rl byte");
    send(3'd0, 1'b1, 16'h8001, 8'h11, 8'h22, 1'b1, "R2 rl word");
    send(3'd1, 1'b0, 16'h0001, 8'h00, 8'h00, 1'b0, "R3 rr byte zero");
    send(3'd1, 1'b1, 16'h1234, 8'h00, 8'h00, 1'b1, "R3 rr word");
    send(3'd2, 1'b0, 16'hFF81, 8'h00, 8'h00, 1'b0, "R4 rlc byte upper ignored R6");
    send(3'd3, 1'b1, 16'h0001, 8'h00, 8'h00, 1'b0, "R4 rrc word");
    send(3'd3, 1'b0, 16'h00FE, 8'h00, 8'h00, 1'b1, "R4 rrc byte");
    send(3'd4, 1'b0, 16'h0080, 8'h00, 8'h00, 1'b0, "R5 sla byte zero");
    send(3'd4, 1'b1, 16'hC003, 8'h00, 8'h00, 1'b1, "R5 sla word");
    send(3'd0, 1'b1, 16'h00FF, 8'h00, 8'h00, 1'b0, "R6 word uses high bits R7");
    send(3'd5, 1'b0, 16'h0000, 8'h3C, 8'h5A, 1'b1, "R8 digit left");
    send(3'd6, 1'b1, 16'hFFFF, 8'h3C, 8'h5A, 1'b0, "R9 digit right");
    send(3'd6, 1'b0, 16'h0000, 8'h00, 8'h00, 1'b1, "R10 digit zero acc");
    idle();
    idle();

    // R11: code 7 must leave every output as it was
    send(3'd2, 1'b1, 16'hA5C3, 8'h12, 8'h34, 1'b1, "R12 before ignore");
    @(negedge clk);
    valid_i = 1'b1; op_i = 3'd7; operand_i = 16'hFFFF; acc_i = 8'hFF; mem_i = 8'hFF; carry_i = 1'b0;
    snap = {result_o, acc_o, mem_o, fs, fz, fh, fpv, fn, fc};
    @(negedge clk);
    valid_i = 1'b0;
    check("R11 code 7 valid low", 64'(valid_o), 64'(0));
    check("R11 code 7 holds", 64'({result_o, acc_o, mem_o, fs, fz, fh, fpv, fn, fc}), 64'(snap));
    @(negedge clk);
    check("R12 idle holds", 64'({valid_o, result_o, acc_o, mem_o, fs, fz, fh, fpv, fn, fc}), 64'({1'b0, snap}));

    for (int i = 0; i < 60; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      send(3'(lfsr[2:0] % 7), lfsr[3], lfsr[31:16], lfsr[11:4], lfsr[19:12], lfsr[20],
           "R2 R3 R4 R5 R7 R8 R9 R10 mixed");
    end
    idle();
    repeat (3) @(negedge clk);
    check("R12 queue drained", 64'(q_exp.size()), 64'(0));
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R12 watchdog got=timeout exp=finish");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule